// File: doc/BRIEF.md
# Programmable Almost-Full/Almost-Empty Flag Unit

This block produces the level flags of a 512-word FIFO from the FIFO's current word count. It drives a half-full flag and one combined flag that is high when the FIFO is close to either end. The low end is set by an almost-empty offset X and the high end by an almost-full offset Y. The storage array and the pointer synchronization belong to neighbouring blocks. This block receives the word count and the write-accept strobe from them.

Both offsets are 8 bits wide and reset to 128. Between reset and the first data write, the write port can load them by pulling the active-low program enable. The first clock edge with program enable low copies the low data byte into both offsets. A second edge that follows at once rewrites only Y. While programming is in progress the unit raises a store-block signal, so the FIFO keeps that data byte out of its array. After the first accepted write, or once program enable has gone high again after a program edge, the offsets are frozen until the next reset.

Top module: `almostFlagUnit`

## Requirements
- R1: `almostFlag` is high when `wordCount` <= X or `wordCount` >= 512 - Y, and low otherwise. The flags are combinational in the count and in the stored offsets.
- R2: If no program edge occurs after reset, X and Y are both 128.
- R3: The first rising edge after reset with `progEnN` low stores `wrData[7:0]` into both X and Y. A program edge is accepted at any time after reset as long as no write has been accepted.
- R4: If `progEnN` is still low at the edge immediately after the first program edge, Y takes the `wrData` value of that edge and X keeps its value.
- R5: After an edge with `wrAccept` high and `progEnN` high, `progEnN` has no effect on X or Y until the next reset.
- R6: After a program edge followed by an edge with `progEnN` high, further program edges have no effect on X or Y. At most two program edges are honoured per reset.
- R7: `halfFull` is high when `wordCount` >= 256 and low when it is 255 or less.
- R8: While `rstN` is low, `almostFlag` is high, `halfFull` is low and `storeBlock` is low, whatever the count and the other inputs.
- R9: Each offset holds values up to 255. With X = Y = 255, `almostFlag` is low only at a count of 256.
- R10: `storeBlock` is high exactly in the cycles where `progEnN` is low and a program edge will be honoured. If `wrAccept` is high in such a cycle, the program edge takes precedence and the unit does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rstN | input | 1 | Synchronous reset, active low |
| progEnN | input | 1 | Offset program enable, active low |
| wrData | input | 8 | Low byte of the write data, used as the offset value |
| wrAccept | input | 1 | A data write is requested at this edge |
| wordCount | input | 10 | Current number of stored words, 0 to 512 |
| halfFull | output | 1 | High at 256 or more words |
| almostFlag | output | 1 | Combined almost-empty/almost-full flag |
| storeBlock | output | 1 | Keeps the write-port data out of the array during a program cycle |

## Verification
A program edge and a data write can fall on the same clock edge. This happens when `progEnN` is low while `wrAccept` is high right after reset. The bench drives exactly that pattern and expects three things: `storeBlock` is high before the edge, the data byte lands in both offsets, and a second program edge is still honoured afterwards. The effect is then judged at the flag outputs, at counts just inside and just outside each programmed threshold.

// File: rtl/almostFlagPkg.sv
package almostFlagPkg;

  // programming phase after reset
  typedef enum logic [1:0] {
    PH_OPEN   = 2'd0,  // no program edge yet, no write yet
    PH_SECOND = 2'd1,  // one program edge taken, a second may follow
    PH_LOCKED = 2'd2   // offsets frozen until reset
  } progPhase_e;

  // strobes from control to the offset datapath
  typedef struct packed {
    logic loadBoth;  // write X and Y
    logic loadFull;  // write Y only
  } ofsLoad_t;

endpackage

// File: rtl/almostFlagCtrl.sv
module almostFlagCtrl
  import almostFlagPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     progEnN,
  input  logic     wrAccept,
  output ofsLoad_t loadStb
);

  progPhase_e phase, phaseNext;

  always_comb begin
    loadStb.loadBoth = rstN && !progEnN && (phase == PH_OPEN);
    loadStb.loadFull = rstN && !progEnN && (phase == PH_SECOND);
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_OPEN: begin
        if (!progEnN)     phaseNext = PH_SECOND;  // program beats write
        else if (wrAccept) phaseNext = PH_LOCKED;
      end
      PH_SECOND: phaseNext = PH_LOCKED;  // second edge or release both lock
      default:   phaseNext = PH_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_OPEN;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/almostFlagPath.sv
module almostFlagPath
  import almostFlagPkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int OFS_W       = 8,
  parameter int DEFAULT_OFS = 128,
  localparam int CNT_W      = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ofsLoad_t         loadStb,
  input  logic [OFS_W-1:0] wrData,
  input  logic [CNT_W-1:0] wordCount,
  output logic [OFS_W-1:0] aeOfs,
  output logic [OFS_W-1:0] afOfs,
  output logic             almostFlag,
  output logic             halfFull
);

  localparam logic [CNT_W-1:0] HALF_LVL  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] DEPTH_LVL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fullEdge;
  logic             nearEmpty, nearFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aeOfs <= OFS_W'(DEFAULT_OFS);
      afOfs <= OFS_W'(DEFAULT_OFS);
    end else begin
      if (loadStb.loadBoth) aeOfs <= wrData;
      if (loadStb.loadBoth || loadStb.loadFull) afOfs <= wrData;
    end
  end

  always_comb begin
    fullEdge   = DEPTH_LVL - CNT_W'(afOfs);
    nearEmpty  = wordCount <= CNT_W'(aeOfs);
    nearFull   = wordCount >= fullEdge;
    almostFlag = !rstN || nearEmpty || nearFull;
    halfFull   = rstN && (wordCount >= HALF_LVL);
  end

endmodule

// File: rtl/almostFlagUnit.sv
module almostFlagUnit
  import almostFlagPkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int OFS_W       = 8,
  parameter int DEFAULT_OFS = 128,
  localparam int CNT_W      = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             progEnN,
  input  logic [OFS_W-1:0] wrData,
  input  logic             wrAccept,
  input  logic [CNT_W-1:0] wordCount,
  output logic             halfFull,
  output logic             almostFlag,
  output logic             storeBlock
);

  ofsLoad_t         loadStb;
  logic [OFS_W-1:0] aeOfs, afOfs;

  almostFlagCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .progEnN  (progEnN),
    .wrAccept (wrAccept),
    .loadStb  (loadStb)
  );

  almostFlagPath #(
    .DEPTH       (DEPTH),
    .OFS_W       (OFS_W),
    .DEFAULT_OFS (DEFAULT_OFS)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .loadStb    (loadStb),
    .wrData     (wrData),
    .wordCount  (wordCount),
    .aeOfs      (aeOfs),
    .afOfs      (afOfs),
    .almostFlag (almostFlag),
    .halfFull   (halfFull)
  );

  assign storeBlock = loadStb.loadBoth || loadStb.loadFull;

endmodule

// File: rtl/almostFlagChk.sv
module almostFlagChk #(
  parameter int DEPTH = 512,
  parameter int OFS_W = 8,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             progEnN,
  input logic [OFS_W-1:0] wrData,
  input logic [CNT_W-1:0] wordCount,
  input logic [OFS_W-1:0] aeOfs,
  input logic [OFS_W-1:0] afOfs,
  input logic             halfFull,
  input logic             almostFlag,
  input logic             storeBlock
);

  AST_ALMOST_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    almostFlag == ((int'(wordCount) <= int'(aeOfs)) ||
                   (int'(wordCount) >= DEPTH - int'(afOfs))));  // R1

  AST_HALF_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    halfFull == (int'(wordCount) >= DEPTH / 2));  // R7

  AST_PROG_LOADS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    storeBlock |=> afOfs == $past(wrData));  // R3

  AST_SECOND_KEEPS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    storeBlock && $past(storeBlock) |=> $stable(aeOfs));  // R4

  AST_TWO_EDGES_MAX: assert property (@(posedge clk) disable iff (!rstN)
    storeBlock && $past(storeBlock) |=> !storeBlock);  // R6

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !progEnN && !storeBlock |=> $stable(aeOfs) && $stable(afOfs));  // R5

  AST_BLOCK_NEEDS_PROG: assert property (@(posedge clk) disable iff (!rstN)
    storeBlock |-> !progEnN);  // R10

  always_comb begin
    if (rstN === 1'b0) begin
      AST_RESET_FLAGS: assert (almostFlag && !halfFull && !storeBlock);  // R8
    end
  end

endmodule

bind almostFlagUnit almostFlagChk #(
  .DEPTH (DEPTH),
  .OFS_W (OFS_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .progEnN    (progEnN),
  .wrData     (wrData),
  .wordCount  (wordCount),
  .aeOfs      (aeOfs),
  .afOfs      (afOfs),
  .halfFull   (halfFull),
  .almostFlag (almostFlag),
  .storeBlock (storeBlock)
);

// File: tb/almostFlagUnit_tb.sv
module almostFlagUnit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 512;

  // {edges[1:0], first value, second value}
  localparam logic [17:0] SCEN_TAB [0:4] = '{
    {2'd0, 8'd0,   8'd0},
    {2'd1, 8'd40,  8'd0},
    {2'd2, 8'd30,  8'd200},
    {2'd2, 8'd255, 8'd255},
    {2'd1, 8'd0,   8'd0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progEnN = 1'b1;
  logic [7:0] wrData = '0;
  logic       wrAccept = 1'b0;
  logic [9:0] wordCount = '0;
  logic       halfFull, almostFlag, storeBlock;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  almostFlagUnit u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .progEnN    (progEnN),
    .wrData     (wrData),
    .wrAccept   (wrAccept),
    .wordCount  (wordCount),
    .halfFull   (halfFull),
    .almostFlag (almostFlag),
    .storeBlock (storeBlock)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; progEnN = 1'b1; wrAccept = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic progEdge(input logic [7:0] d, input logic expBlock, input string tag);
    @(negedge clk);
    progEnN = 1'b0; wrData = d; wrAccept = 1'b0;
    #1 chk(tag, storeBlock, expBlock);
    @(posedge clk);
  endtask

  task automatic writeEdge();
    @(negedge clk);
    progEnN = 1'b1; wrAccept = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrAccept = 1'b0;
  endtask

  task automatic idleEdge();
    @(negedge clk);
    progEnN = 1'b1; wrAccept = 1'b0;
    @(posedge clk);
  endtask

  task automatic probe(input int c, input int x, input int y, input string tag);
    wordCount = 10'(c);
    #1;
    chk({tag, " R1 almost"}, almostFlag, (c <= x) || (c >= DEPTH - y));
    chk({tag, " R7 half"}, halfFull, c >= DEPTH / 2);
  endtask

  task automatic sweep(input int x, input int y, input string tag);
    @(negedge clk);
    progEnN = 1'b1; wrAccept = 1'b0;
    for (int c = 0; c <= DEPTH; c++) probe(c, x, y, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset forces flags, block stays low even with program enable low
    rstN = 1'b0; wordCount = 10'd300; progEnN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 almost in reset", almostFlag, 1'b1);
    chk("R8 half in reset", halfFull, 1'b0);
    chk("R8 block in reset", storeBlock, 1'b0);
    progEnN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;

    // table walk: R2 defaults, R3 one edge, R4 two edges, R9 maximum
    for (int s = 0; s < 5; s++) begin
      int n, xv, yv, ex, ey;
      string tag;
      n  = int'(SCEN_TAB[s][17:16]);
      xv = int'(SCEN_TAB[s][15:8]);
      yv = int'(SCEN_TAB[s][7:0]);
      ex = (n == 0) ? 128 : xv;
      ey = (n == 2) ? yv : ((n == 1) ? xv : 128);
      tag = (n == 0) ? "R2" : (n == 1) ? "R3" : (xv == 255) ? "R9" : "R4";
      doReset();
      if (n >= 1) progEdge(8'(xv), 1'b1, {tag, " block"});
      if (n == 2) progEdge(8'(yv), 1'b1, {tag, " block second"});
      writeEdge();
      sweep(ex, ey, tag);
    end

    // R10: program and write in the same cycle; program wins, no lock
    doReset();
    @(negedge clk);
    progEnN = 1'b0; wrData = 8'd50; wrAccept = 1'b1;
    #1 chk("R10 block with write", storeBlock, 1'b1);
    @(posedge clk);
    progEdge(8'd90, 1'b1, "R10 second edge honoured");
    idleEdge();
    probe(50, 50, 90, "R10");
    probe(51, 50, 90, "R10");
    probe(421, 50, 90, "R10");
    probe(422, 50, 90, "R10");

    // R3: idle edges before programming keep it open
    doReset();
    repeat (3) idleEdge();
    progEdge(8'd10, 1'b1, "R3 late program");
    idleEdge();
    probe(10, 10, 10, "R3 late");
    probe(11, 10, 10, "R3 late");
    probe(502, 10, 10, "R3 late");

    // R5: write locks; later program edge ignored
    doReset();
    writeEdge();
    progEdge(8'd10, 1'b0, "R5 block after write");
    idleEdge();
    probe(128, 128, 128, "R5");
    probe(129, 128, 128, "R5");
    probe(383, 128, 128, "R5");
    probe(384, 128, 128, "R5");

    // R6: release after one edge locks
    doReset();
    progEdge(8'd20, 1'b1, "R6 first");
    idleEdge();
    progEdge(8'd200, 1'b0, "R6 block after release");
    idleEdge();
    probe(20, 20, 20, "R6");
    probe(21, 20, 20, "R6");
    probe(491, 20, 20, "R6");
    probe(492, 20, 20, "R6");

    // R6: a third consecutive program edge is not honoured
    doReset();
    progEdge(8'd60, 1'b1, "R6 three edges a");
    progEdge(8'd70, 1'b1, "R6 three edges b");
    progEdge(8'd5,  1'b0, "R6 three edges c");
    idleEdge();
    probe(60, 60, 70, "R6 three");
    probe(61, 60, 70, "R6 three");
    probe(441, 60, 70, "R6 three");
    probe(442, 60, 70, "R6 three");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule